// File: doc/BRIEF.md
# Register Pointer With Shadow Snapshot

This block is the byte-wide register file that sits behind a 2-wire slave protocol engine in a real-time-clock design. It presents a 64-byte address space. The low eight addresses belong to the timekeeping and control counters, and the rest is general-purpose RAM. The protocol engine tells the block when a transaction starts and stops, and strobes it once per received or requested byte. The block interprets those strobes with an auto-incrementing pointer. After the top of RAM, the pointer wraps back into the clock space.

Reads of the clock space come from a shadow copy of the live time, not from the counters. The block copies the live time into the shadow at each transaction start, at each transaction stop, and whenever the pointer steps round to address zero. A multibyte read therefore returns one consistent instant, even while the counters keep running.

Writes to the clock space go to the counters as a one-cycle load strobe that carries the register index and the data. Writes to RAM update the internal memory. While the power-fail input is high, the clock space is blocked and RAM stays accessible.

Top module: `rtc_regfile_front`

## Requirements
- R1: Addresses 00h to 07h select the clock/control registers and 08h to 3Fh select RAM; a byte written to RAM is returned unchanged by a later read of the same address.
- R2: Every data read or data write advances the pointer by one, and an access at 3Fh leaves the pointer at 00h.
- R3: The live time (byte i taken from `time_live[8i+7:8i]`) is copied into the shadow on the clock edge of `bus_start`, of `bus_stop`, and of any access that wraps the pointer from 3Fh to 00h.
- R4: A read of address i in 00h to 07h returns shadow byte i, so later changes of `time_live` are not visible until the next capture.
- R5: The first `wr_stb` after `bus_start` is a pointer byte: its low six bits load the pointer, nothing is written, and the pointer does not then increment.
- R6: While `power_fail` is 1, a read of 00h to 07h returns 00h, a write to 00h to 07h raises no `tk_load`, and RAM reads and writes work as normal.
- R7: A write to address i in 00h to 07h raises `tk_load` for exactly the following cycle, with `tk_addr` = i and `tk_data` = the written byte; RAM writes never raise `tk_load`.
- R8: A write to address 00h also raises `tk_div_reset` in the same cycle as its `tk_load`; writes to other addresses do not.
- R9: `rd_valid` is 1 in the cycle after each `rd_stb`, with `rd_data` holding the byte of the address the pointer held at the strobe, and is 0 otherwise.
- R10: `bus_stop` leaves the pointer unchanged, so the next transaction begins its reads at the address where the previous one ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Transaction start strobe |
| bus_stop | input | 1 | Transaction stop strobe |
| wr_stb | input | 1 | Received byte strobe |
| wr_byte | input | 8 | Received byte |
| rd_stb | input | 1 | Byte requested by the master |
| power_fail | input | 1 | Supply failure, blocks the clock space |
| time_live | input | 64 | Live counter values, byte i at bits 8i+7..8i |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data valid |
| tk_load | output | 1 | Load strobe toward the counters |
| tk_addr | output | 3 | Counter register index for tk_load |
| tk_data | output | 8 | Data for tk_load |
| tk_div_reset | output | 1 | Reset the sub-second divider chain |

## Verification
On every cycle, the assertions check the pointer arithmetic: the step, the wrap at 3Fh, pointer-byte loading and holding across a stop. They also check that blocked accesses stay silent under power fail, and how `tk_load`, `tk_div_reset` and `rd_valid` relate to the strobes that cause them. Only the bench scenarios show the snapshot behaviour. Those scenarios read the clock space after `time_live` has moved on, capture on a wrap, and check RAM contents and current-address reads across transactions against a model of the memory and shadow.

// File: rtl/rtcrf_pkg.sv
package rtcrf_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PTR   = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_READ  = 2'd3
  } acc_e;
endpackage

// File: rtl/rf_pointer.sv
module rf_pointer
  import rtcrf_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] ptr,
  output acc_e              acc,
  output logic              wrap_evt
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic expect_ptr;

  always_comb begin
    if (wr_stb && expect_ptr) acc = ACC_PTR;
    else if (wr_stb)          acc = ACC_WRITE;
    else if (rd_stb)          acc = ACC_READ;
    else                      acc = ACC_NONE;
  end

  assign wrap_evt = ((acc == ACC_WRITE) || (acc == ACC_READ)) && (ptr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      expect_ptr <= 1'b0;
    end else begin
      case (acc)
        ACC_PTR: begin
          ptr        <= load_val;
          expect_ptr <= 1'b0;
        end
        ACC_WRITE, ACC_READ: begin
          ptr        <= ptr + 1'b1;
          expect_ptr <= 1'b0;
        end
        default: ;
      endcase
      if (bus_start)     expect_ptr <= 1'b1;
      else if (bus_stop) expect_ptr <= 1'b0;
    end
  end
endmodule

// File: rtl/rf_shadow.sv
module rf_shadow #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   capture,
  input  logic [NREG*DATA_W-1:0] live,
  input  logic                   rd_en,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic                   blocked,
  output logic [DATA_W-1:0]      q
);
  logic [DATA_W-1:0] snap [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_cap
    always_ff @(posedge clk) begin
      if (rst)          snap[g] <= '0;
      else if (capture) snap[g] <= live[g*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (rd_en) q <= blocked ? '0 : snap[rd_idx];
  end
endmodule

// File: rtl/rf_ram.sv
module rf_ram #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/rtc_regfile_front.sv
module rtc_regfile_front
  import rtcrf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CLK_REGS = 8,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned IDX_W   = $clog2(CLK_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_start,
  input  logic                       bus_stop,
  input  logic                       wr_stb,
  input  logic [DATA_W-1:0]          wr_byte,
  input  logic                       rd_stb,
  input  logic                       power_fail,
  input  logic [CLK_REGS*DATA_W-1:0] time_live,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       rd_valid,
  output logic                       tk_load,
  output logic [IDX_W-1:0]           tk_addr,
  output logic [DATA_W-1:0]          tk_data,
  output logic                       tk_div_reset
);
  localparam logic [ADDR_W-1:0] CLK_END = ADDR_W'(CLK_REGS);

  logic [ADDR_W-1:0] ptr;
  acc_e              acc_kind;
  logic              wrap_evt;
  logic              in_clk;
  logic              sel_clk_q;
  logic [DATA_W-1:0] clk_q;
  logic [DATA_W-1:0] ram_q;
  logic              ram_we;
  logic              clk_we;

  rf_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .load_val (wr_byte[ADDR_W-1:0]),
    .ptr      (ptr),
    .acc      (acc_kind),
    .wrap_evt (wrap_evt)
  );

  assign in_clk = (ptr < CLK_END);
  assign ram_we = (acc_kind == ACC_WRITE) && !in_clk;
  assign clk_we = (acc_kind == ACC_WRITE) && in_clk && !power_fail;

  rf_shadow #(.NREG(CLK_REGS), .DATA_W(DATA_W)) u_shadow (
    .clk    (clk),
    .rst    (rst),
    .capture(bus_start || bus_stop || wrap_evt),
    .live   (time_live),
    .rd_en  (acc_kind == ACC_READ),
    .rd_idx (ptr[IDX_W-1:0]),
    .blocked(power_fail),
    .q      (clk_q)
  );

  rf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (acc_kind == ACC_READ),
    .addr (ptr),
    .wdata(wr_byte),
    .q    (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      sel_clk_q    <= 1'b0;
      tk_load      <= 1'b0;
      tk_addr      <= '0;
      tk_data      <= '0;
      tk_div_reset <= 1'b0;
    end else begin
      rd_valid     <= (acc_kind == ACC_READ);
      if (acc_kind == ACC_READ) sel_clk_q <= in_clk;
      tk_load      <= clk_we;
      tk_div_reset <= clk_we && (ptr == '0);
      if (clk_we) begin
        tk_addr <= ptr[IDX_W-1:0];
        tk_data <= wr_byte;
      end
    end
  end

  assign rd_data = sel_clk_q ? clk_q : ram_q;
endmodule

// File: rtl/rtc_regfile_front_chk.sv
module rtc_regfile_front_chk
  import rtcrf_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned CLK_REGS = 8,
  parameter int unsigned DATA_W   = 8,
  localparam int unsigned IDX_W   = $clog2(CLK_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_stop,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_byte,
  input logic              rd_stb,
  input logic              power_fail,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              tk_load,
  input logic [IDX_W-1:0]  tk_addr,
  input logic              tk_div_reset,
  input logic [ADDR_W-1:0] ptr,
  input acc_e              acc_kind
);
  localparam logic [ADDR_W-1:0] LAST    = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] CLK_END = ADDR_W'(CLK_REGS);

  logic data_acc;
  assign data_acc = (acc_kind == ACC_WRITE) || (acc_kind == ACC_READ);

  p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (data_acc && ptr == LAST) |=> (ptr == '0));

  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (data_acc && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));

  p_ptr_load_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_PTR) |=> (ptr == $past(wr_byte[ADDR_W-1:0])));

  p_stop_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_stop && !wr_stb && !rd_stb) |=> $stable(ptr));

  p_pf_no_load_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_WRITE && power_fail && ptr < CLK_END) |=> !tk_load);

  p_pf_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_READ && power_fail && ptr < CLK_END) |=> (rd_data == '0));

  p_load_cause_r7: assert property (@(posedge clk) disable iff (rst)
    tk_load |-> ($past(acc_kind) == ACC_WRITE && $past(ptr) < CLK_END));

  p_div_reset_r8: assert property (@(posedge clk) disable iff (rst)
    tk_div_reset |-> (tk_load && tk_addr == '0));

  p_rd_valid_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_stb));
endmodule

bind rtc_regfile_front rtc_regfile_front_chk #(
  .ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_stop(bus_stop), .wr_stb(wr_stb),
  .wr_byte(wr_byte), .rd_stb(rd_stb), .power_fail(power_fail),
  .rd_data(rd_data), .rd_valid(rd_valid), .tk_load(tk_load),
  .tk_addr(tk_addr), .tk_div_reset(tk_div_reset), .ptr(ptr),
  .acc_kind(acc_kind)
);

// File: tb/rtc_regfile_front_test.sv
module rtc_regfile_front_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_start = 1'b0, bus_stop = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic        power_fail = 1'b0;
  logic [63:0] time_live = '0;
  logic [7:0]  rd_data;
  logic        rd_valid, tk_load, tk_div_reset;
  logic [2:0]  tk_addr;
  logic [7:0]  tk_data;

  always #2.5 clk = ~clk;

  rtc_regfile_front uut (
    .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
    .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_stb(rd_stb),
    .power_fail(power_fail), .time_live(time_live), .rd_data(rd_data),
    .rd_valid(rd_valid), .tk_load(tk_load), .tk_addr(tk_addr),
    .tk_data(tk_data), .tk_div_reset(tk_div_reset)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  logic [7:0]  mram [64];
  logic [63:0] m_snap = '0;
  logic [5:0]  m_ptr = '0;
  bit          m_pending = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R9 unexpected rd_valid", 1, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rd_data === e, t, rd_data, e);
      end
    end
  end

  task automatic step_ptr();
    if (m_ptr == 6'h3F) m_snap = time_live;
    m_ptr = m_ptr + 1'b1;
  endtask

  task automatic do_start();
    @(negedge clk); bus_start = 1;
    @(negedge clk); bus_start = 0;
    m_snap = time_live; m_pending = 1;
  endtask

  task automatic do_stop();
    @(negedge clk); bus_stop = 1;
    @(negedge clk); bus_stop = 0;
    m_snap = time_live; m_pending = 0;
  endtask

  task automatic do_wr(input logic [7:0] b);
    @(negedge clk); wr_stb = 1; wr_byte = b;
    @(negedge clk); wr_stb = 0;
    if (m_pending) begin
      m_ptr = b[5:0]; m_pending = 0;
    end else begin
      if (m_ptr < 8) begin
        if (power_fail) chk(tk_load === 1'b0, "R6 blocked write", tk_load, 0);
        else begin
          chk(tk_load === 1'b1 && tk_addr === m_ptr[2:0] && tk_data === b,
              "R7 counter load", {tk_load, 5'd0, tk_addr, tk_data}, {1'b1, 5'd0, m_ptr[2:0], b});
          chk(tk_div_reset === (m_ptr == 0), "R8 divider reset", tk_div_reset, m_ptr == 0);
        end
      end else begin
        mram[m_ptr] = b;
        chk(tk_load === 1'b0, "R7 RAM write no load", tk_load, 0);
      end
      step_ptr();
    end
  endtask

  task automatic do_rd(input string tag);
    logic [7:0] e;
    if (m_ptr < 8) e = power_fail ? 8'h00 : m_snap[m_ptr*8 +: 8];
    else e = mram[m_ptr];
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    m_pending = 0;
    step_ptr();
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rd_valid === 0 && tk_load === 0 && tk_div_reset === 0, "R9 reset state",
        {rd_valid, tk_load, tk_div_reset}, 0);

    // R1 R5: RAM write burst at 08h
    do_start(); do_wr(8'h08); do_wr(8'hA1); do_wr(8'hB2); do_wr(8'hC3); do_stop();
    // R10: pointer reload, stop, then current-address reads
    do_start(); do_wr(8'h08); do_stop();
    do_start(); do_rd("R10 R1 RAM 08h"); do_rd("R1 RAM 09h"); do_rd("R1 RAM 0Ah"); do_stop();

    // R3 R4: snapshot on start, live moves during the read burst
    time_live = 64'h0807_0605_0403_0201;
    do_start(); do_wr(8'h00); do_stop();
    time_live = 64'h1817_1615_1413_1211;
    do_start();
    do_rd("R3 snapshot byte 0");
    time_live = 64'hF8F7_F6F5_F4F3_F2F1;
    for (int i = 1; i < 8; i++) do_rd("R4 buffered byte");
    do_stop();

    // R2 R3: write wrap at 3Fh captures live time
    do_start(); do_wr(8'h3E);
    time_live = 64'h2827_2625_2423_2221;
    do_wr(8'h5A); do_wr(8'h6B);
    time_live = 64'h3837_3635_3433_3231;
    do_rd("R2 R3 wrap snapshot byte 0"); do_rd("R3 wrap snapshot byte 1");
    do_stop();

    // R2: read wrap from 3Fh
    do_start(); do_wr(8'h3E); do_stop();
    do_start(); do_rd("R1 RAM 3Eh"); do_rd("R2 RAM 3Fh");
    time_live = 64'h4847_4645_4443_4241;
    do_rd("R2 after read wrap byte 0");
    do_stop();

    // R7 R8: counter writes
    do_start(); do_wr(8'h00); do_wr(8'h45); do_wr(8'h12); do_wr(8'h07); do_stop();

    // R6: power fail
    power_fail = 1;
    do_start(); do_wr(8'h02); do_wr(8'h33); do_rd("R6 blocked read 03h"); do_stop();
    do_start(); do_wr(8'h0A); do_wr(8'h77); do_stop();
    do_start(); do_wr(8'h09); do_stop();
    do_start(); do_rd("R6 RAM read 09h under fail"); do_rd("R6 RAM 0Ah written under fail"); do_stop();
    power_fail = 0;
    do_start(); do_wr(8'h05); do_stop();
    do_start(); do_rd("R4 shadow byte 5 after fail"); do_stop();

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R9 reads outstanding", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule